// File: doc/BRIEF.md
# GPIO Pin Bank Register File

This block is the register file for one bank of up to 64 general-purpose pins. Software changes the output latch only through two strobe registers. Writing ones to one of them raises the chosen latch bits, and writing ones to the other lowers them, so no read-modify-write sequence is needed. The file also gives software a raw view of the pad inputs and a fixed capability word. Each pin has its own 64-bit configuration word. That word holds the output enable, the polarity flip, open-drain mode, an interrupt enable and type, a filter setting, and a function selector.

From the latch and the configuration words, the block drives the output enable and output value of every pad. When a pin's function selector is nonzero, the pin belongs to another on-chip function. The pad then follows that function's own enable and value, and the strobe registers no longer touch that pin.

The block has two write lanes and one read lane. Lane A and lane B can each write in the same cycle. The read lane returns data one cycle after its request, and that data holds until the next read.

Top module: `gpio_bank_regs`

## Requirements
- R1: While reset is asserted, and directly after it, every output latch bit and every configuration word is zero. Every pad output enable is 0, every pad output value is 0, and every pin acts as a GPIO input.
- R2: Writing a word to offset 0x08 sets the latch bits that hold ones in that word. A read of 0x08 returns the current latch.
- R3: Writing a word to offset 0x10 clears the latch bits that hold ones in that word.
- R4: When the two lanes write the set and clear registers in the same cycle, each bit is handled on its own. A bit that both writes name ends up cleared, and bits named by only one of the writes are set or cleared as that write asks.
- R5: A read of offset 0x00 returns the pad input vector as it was in the cycle of the read request.
- R6: A read of offset 0x90 returns the pin count in bits 7:0 and the base interrupt vector in bits 15:8. All other bits read as zero.
- R7: The configuration word of pin p sits at 0x400 + 8·p. Its fields are output enable (bit 0), polarity flip (bit 1), interrupt enable (bit 2), interrupt type (bit 3), filter (bits 11:4), open-drain (bit 12) and function select (bits 25:16). All other bits read as zero.
- R8: For a GPIO pin with the output enable set and open-drain clear, the pad enable is 1 and the pad value is the latch bit XOR the polarity flip. With the output enable clear, the pad enable is 0.
- R9: For a GPIO pin with both the output enable and open-drain set, the pad value is always 0. The pad enable is 1 only when the latch bit XOR the polarity flip is 0.
- R10: For a pin with a nonzero function select, the pad enable and value follow the alternate function's inputs. Writes to 0x08 and 0x10 leave that pin's latch bit unchanged.
- R11: When both lanes write the same configuration word in the same cycle, the value from lane B is kept.
- R12: A read of an unmapped offset returns zero, and a write to one has no effect. Unmapped offsets include the gaps between registers, any offset that is not a multiple of 8, and any configuration address past the last pin.
- R13: A read that falls in the same cycle as a write to the same register returns the value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wa_en | input | 1 | Lane A write strobe |
| wa_addr | input | 16 | Lane A byte offset |
| wa_data | input | 64 | Lane A write data |
| wb_en | input | 1 | Lane B write strobe |
| wb_addr | input | 16 | Lane B byte offset |
| wb_data | input | 64 | Lane B write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | 16 | Read byte offset |
| rd_data | output | 64 | Read data, valid from the cycle after the request until the next read |
| pad_in | input | NPIN (64) | Raw pad input levels |
| alt_oe | input | NPIN (64) | Pad output enables from the alternate functions |
| alt_out | input | NPIN (64) | Pad output values from the alternate functions |
| pad_oe | output | NPIN (64) | Pad output enables |
| pad_out | output | NPIN (64) | Pad output values |

## Verification
Three pairs of operations can land in the same cycle. In the first, a set strobe on one lane meets a clear strobe on the other lane. The test drives both lanes on the same clock edge, once with overlapping masks and once with separate masks, and in both lane orders. It then compares the latch readback bit by bit against the rule that a clear wins. In the second, both lanes write one configuration word at once, and the readback must show lane B's value. In the third, a read request shares an edge with a set write to the same register. The read must return the old latch and a later read the new one.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int WORD_W = 64;
    localparam int ADDR_W = 16;

    localparam logic [ADDR_W-1:0] OFS_RAW = 16'h0000;
    localparam logic [ADDR_W-1:0] OFS_SET = 16'h0008;
    localparam logic [ADDR_W-1:0] OFS_CLR = 16'h0010;
    localparam logic [ADDR_W-1:0] OFS_CAP = 16'h0090;
    localparam logic [ADDR_W-1:0] OFS_CFG = 16'h0400;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_RAW,
        RG_SET,
        RG_CLR,
        RG_CAP,
        RG_CFG
    } reg_sel_e;

    typedef struct packed {
        logic [9:0] fsel;
        logic       od;
        logic [7:0] filt;
        logic       irq_type;
        logic       irq_en;
        logic       inv;
        logic       oe;
    } pin_cfg_t;

    function automatic reg_sel_e decode_ofs(logic [ADDR_W-1:0] a, int unsigned npin);
        reg_sel_e r;
        logic [ADDR_W:0] top_cfg;
        top_cfg = {1'b0, OFS_CFG} + (ADDR_W+1)'(8 * npin);
        r = RG_NONE;
        if (a[2:0] == 3'b000) begin
            if (a == OFS_RAW)      r = RG_RAW;
            else if (a == OFS_SET) r = RG_SET;
            else if (a == OFS_CLR) r = RG_CLR;
            else if (a == OFS_CAP) r = RG_CAP;
            else if (a >= OFS_CFG && {1'b0, a} < top_cfg) r = RG_CFG;
        end
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] cfg_to_word(pin_cfg_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[0]     = c.oe;
        w[1]     = c.inv;
        w[2]     = c.irq_en;
        w[3]     = c.irq_type;
        w[11:4]  = c.filt;
        w[12]    = c.od;
        w[25:16] = c.fsel;
        return w;
    endfunction

endpackage

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
    parameter int NPIN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] set_req,
    input  logic [NPIN-1:0] clr_req,
    input  logic [NPIN-1:0] gpio_ok,
    output logic [NPIN-1:0] latch_q
);

    logic [NPIN-1:0] set_eff;
    logic [NPIN-1:0] clr_eff;

    always_comb begin
        set_eff = set_req & gpio_ok;
        clr_eff = clr_req & gpio_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else begin
            latch_q <= (latch_q | set_eff) & ~clr_eff;
        end
    end

    // R4: a bit named by a clear strobe is low after the edge
    p_clear_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_req & gpio_ok)) |=> ((latch_q & $past(clr_req & gpio_ok)) == '0));

    // R2: a bit named only by a set strobe is high after the edge
    p_set_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_req & ~clr_req & gpio_ok)) |=>
        ((latch_q & $past(set_req & ~clr_req & gpio_ok)) == $past(set_req & ~clr_req & gpio_ok)));

    // R10: a pin owned by another function keeps its latch bit
    p_alt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((latch_q ^ $past(latch_q)) & ~$past(gpio_ok)) == '0));

endmodule

// File: rtl/gpio_cfg_store.sv
module gpio_cfg_store
    import gpio_bank_pkg::*;
#(
    parameter int NPIN   = 64,
    parameter int PIDX_W = (NPIN > 1) ? $clog2(NPIN) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        a_we,
    input  logic [PIDX_W-1:0]           a_idx,
    input  pin_cfg_t                    a_cfg,
    input  logic                        b_we,
    input  logic [PIDX_W-1:0]           b_idx,
    input  pin_cfg_t                    b_cfg,
    output pin_cfg_t [NPIN-1:0]         cfg_q
);

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        logic hit_a;
        logic hit_b;
        assign hit_a = a_we && (a_idx == PIDX_W'(p));
        assign hit_b = b_we && (b_idx == PIDX_W'(p));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[p] <= '0;
            end else if (hit_b) begin
                cfg_q[p] <= b_cfg;
            end else if (hit_a) begin
                cfg_q[p] <= a_cfg;
            end
        end
    end

    // R11: lane B is kept when both lanes hit one word
    p_lane_b_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (a_we && b_we && a_idx == b_idx) |=> (cfg_q[$past(b_idx)] == $past(b_cfg)));

    // R7: a word no lane writes stays as it was
    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_we && !b_we) |=> $stable(cfg_q));

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
    parameter int NPIN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] latch_q,
    input  logic [NPIN-1:0] cfg_oe,
    input  logic [NPIN-1:0] cfg_inv,
    input  logic [NPIN-1:0] cfg_od,
    input  logic [NPIN-1:0] gpio_ok,
    input  logic [NPIN-1:0] alt_oe,
    input  logic [NPIN-1:0] alt_out,
    output logic [NPIN-1:0] pad_oe,
    output logic [NPIN-1:0] pad_out
);

    for (genvar p = 0; p < NPIN; p++) begin : g_pad
        logic eff;
        assign eff = latch_q[p] ^ cfg_inv[p];

        always_comb begin
            if (!gpio_ok[p]) begin
                pad_oe[p]  = alt_oe[p];
                pad_out[p] = alt_out[p];
            end else if (!cfg_oe[p]) begin
                pad_oe[p]  = 1'b0;
                pad_out[p] = 1'b0;
            end else if (cfg_od[p]) begin
                pad_oe[p]  = ~eff;
                pad_out[p] = 1'b0;
            end else begin
                pad_oe[p]  = 1'b1;
                pad_out[p] = eff;
            end
        end
    end

    // R9: an open-drain GPIO pin never drives high
    p_od_never_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((gpio_ok & cfg_oe & cfg_od & pad_out) == '0));

    // R8: a GPIO pin without output enable never drives
    p_no_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((gpio_ok & ~cfg_oe & pad_oe) == '0));

endmodule

// File: rtl/gpio_rd_port.sv
module gpio_rd_port
    import gpio_bank_pkg::*;
#(
    parameter int NPIN     = 64,
    parameter int VEC_BASE = 48,
    parameter int PIDX_W   = (NPIN > 1) ? $clog2(NPIN) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [NPIN-1:0]     pad_in,
    input  logic [NPIN-1:0]     latch_q,
    input  pin_cfg_t [NPIN-1:0] cfg_q,
    output logic [WORD_W-1:0]   rd_data
);

    localparam logic [WORD_W-1:0] CAP_WORD =
        {{(WORD_W-16){1'b0}}, 8'(VEC_BASE), 8'(NPIN)};

    reg_sel_e            sel;
    logic [ADDR_W-1:0]   rel;
    logic [PIDX_W-1:0]   idx;
    logic [WORD_W-1:0]   mux;

    always_comb begin
        sel = decode_ofs(rd_addr, NPIN);
        rel = rd_addr - OFS_CFG;
        idx = PIDX_W'(rel >> 3);
        mux = '0;
        unique case (sel)
            RG_RAW:  mux = WORD_W'(pad_in);
            RG_SET:  mux = WORD_W'(latch_q);
            RG_CAP:  mux = CAP_WORD;
            RG_CFG:  mux = cfg_to_word(cfg_q[idx]);
            RG_CLR,
            RG_NONE: mux = '0;
            default: mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= mux;
        end
    end

    // R12: unmapped offsets read as zero
    p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == RG_NONE) |=> (rd_data == '0));

    // R6: capability word carries the pin count
    p_cap_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == RG_CAP) |=> (rd_data[7:0] == 8'(NPIN)));

    // R13: read data holds between requests
    p_rd_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int NPIN     = 64,
    parameter int VEC_BASE = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wa_en,
    input  logic [15:0]        wa_addr,
    input  logic [63:0]        wa_data,
    input  logic               wb_en,
    input  logic [15:0]        wb_addr,
    input  logic [63:0]        wb_data,
    input  logic               rd_en,
    input  logic [15:0]        rd_addr,
    output logic [63:0]        rd_data,
    input  logic [NPIN-1:0]    pad_in,
    input  logic [NPIN-1:0]    alt_oe,
    input  logic [NPIN-1:0]    alt_out,
    output logic [NPIN-1:0]    pad_oe,
    output logic [NPIN-1:0]    pad_out
);

    localparam int PIDX_W = (NPIN > 1) ? $clog2(NPIN) : 1;

    reg_sel_e            sel_a;
    reg_sel_e            sel_b;
    logic [ADDR_W-1:0]   rel_a;
    logic [ADDR_W-1:0]   rel_b;
    logic [NPIN-1:0]     set_req;
    logic [NPIN-1:0]     clr_req;
    logic [NPIN-1:0]     gpio_ok;
    logic [NPIN-1:0]     cfg_oe;
    logic [NPIN-1:0]     cfg_inv;
    logic [NPIN-1:0]     cfg_od;
    logic [NPIN-1:0]     latch_q;
    logic                a_we;
    logic                b_we;
    logic [PIDX_W-1:0]   a_idx;
    logic [PIDX_W-1:0]   b_idx;
    pin_cfg_t            a_cfg;
    pin_cfg_t            b_cfg;
    pin_cfg_t [NPIN-1:0] cfg_q;

    always_comb begin
        sel_a   = decode_ofs(wa_addr, NPIN);
        sel_b   = decode_ofs(wb_addr, NPIN);
        set_req = '0;
        clr_req = '0;
        if (wa_en && sel_a == RG_SET) set_req = set_req | wa_data[NPIN-1:0];
        if (wb_en && sel_b == RG_SET) set_req = set_req | wb_data[NPIN-1:0];
        if (wa_en && sel_a == RG_CLR) clr_req = clr_req | wa_data[NPIN-1:0];
        if (wb_en && sel_b == RG_CLR) clr_req = clr_req | wb_data[NPIN-1:0];
        rel_a = wa_addr - OFS_CFG;
        rel_b = wb_addr - OFS_CFG;
        a_we  = wa_en && sel_a == RG_CFG;
        b_we  = wb_en && sel_b == RG_CFG;
        a_idx = PIDX_W'(rel_a >> 3);
        b_idx = PIDX_W'(rel_b >> 3);
        a_cfg = '{fsel: wa_data[25:16], od: wa_data[12], filt: wa_data[11:4],
                  irq_type: wa_data[3], irq_en: wa_data[2], inv: wa_data[1], oe: wa_data[0]};
        b_cfg = '{fsel: wb_data[25:16], od: wb_data[12], filt: wb_data[11:4],
                  irq_type: wb_data[3], irq_en: wb_data[2], inv: wb_data[1], oe: wb_data[0]};
    end

    for (genvar p = 0; p < NPIN; p++) begin : g_fields
        assign gpio_ok[p] = (cfg_q[p].fsel == '0);
        assign cfg_oe[p]  = cfg_q[p].oe;
        assign cfg_inv[p] = cfg_q[p].inv;
        assign cfg_od[p]  = cfg_q[p].od;
    end

    gpio_out_latch #(.NPIN(NPIN)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (set_req),
        .clr_req (clr_req),
        .gpio_ok (gpio_ok),
        .latch_q (latch_q)
    );

    gpio_cfg_store #(.NPIN(NPIN), .PIDX_W(PIDX_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .a_we  (a_we),
        .a_idx (a_idx),
        .a_cfg (a_cfg),
        .b_we  (b_we),
        .b_idx (b_idx),
        .b_cfg (b_cfg),
        .cfg_q (cfg_q)
    );

    gpio_pad_ctrl #(.NPIN(NPIN)) u_pad (
        .clk     (clk),
        .rst_n   (rst_n),
        .latch_q (latch_q),
        .cfg_oe  (cfg_oe),
        .cfg_inv (cfg_inv),
        .cfg_od  (cfg_od),
        .gpio_ok (gpio_ok),
        .alt_oe  (alt_oe),
        .alt_out (alt_out),
        .pad_oe  (pad_oe),
        .pad_out (pad_out)
    );

    gpio_rd_port #(.NPIN(NPIN), .VEC_BASE(VEC_BASE), .PIDX_W(PIDX_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .pad_in  (pad_in),
        .latch_q (latch_q),
        .cfg_q   (cfg_q),
        .rd_data (rd_data)
    );

    // R1: every pin comes out of reset as an undriven GPIO input
    p_reset_idle_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0));

endmodule

// File: tb/gpio_bank_regs_tb.sv
module gpio_bank_regs_tb_top;

    localparam int NPIN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wa_en = 1'b0;
    logic [15:0]     wa_addr = '0;
    logic [63:0]     wa_data = '0;
    logic            wb_en = 1'b0;
    logic [15:0]     wb_addr = '0;
    logic [63:0]     wb_data = '0;
    logic            rd_en = 1'b0;
    logic [15:0]     rd_addr = '0;
    logic [63:0]     rd_data;
    logic [NPIN-1:0] pad_in = '0;
    logic [NPIN-1:0] alt_oe = '0;
    logic [NPIN-1:0] alt_out = '0;
    logic [NPIN-1:0] pad_oe;
    logic [NPIN-1:0] pad_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_bank_regs #(.NPIN(NPIN), .VEC_BASE(48)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
        .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .pad_in(pad_in), .alt_oe(alt_oe), .alt_out(alt_out),
        .pad_oe(pad_oe), .pad_out(pad_out)
    );

    typedef struct packed {
        logic        a_en;
        logic [15:0] a_addr;
        logic [63:0] a_data;
        logic        b_en;
        logic [15:0] b_addr;
        logic [63:0] b_data;
        logic [63:0] exp;
    } vec_t;

    // set/clear walk; expected latch after each step (R2, R3, R4)
    localparam vec_t VECS [8] = '{
        '{1'b1, 16'h0008, 64'h0000_0000_0000_00FF, 1'b0, 16'h0000, 64'h0, 64'h0000_0000_0000_00FF},
        '{1'b1, 16'h0010, 64'h0000_0000_0000_000F, 1'b0, 16'h0000, 64'h0, 64'h0000_0000_0000_00F0},
        '{1'b1, 16'h0008, 64'hF0F0_0000_0000_0000, 1'b1, 16'h0010, 64'h30, 64'hF0F0_0000_0000_00C0},
        '{1'b1, 16'h0008, 64'h0000_0000_0000_0003, 1'b1, 16'h0010, 64'h1, 64'hF0F0_0000_0000_00C2},
        '{1'b1, 16'h0010, 64'h0000_0000_0000_0002, 1'b1, 16'h0008, 64'h2, 64'hF0F0_0000_0000_00C0},
        '{1'b1, 16'h0008, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 16'h0000, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF},
        '{1'b1, 16'h0010, 64'h8000_0000_0000_0000, 1'b1, 16'h0010, 64'h1, 64'h7FFF_FFFF_FFFF_FFFE},
        '{1'b1, 16'h0010, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 16'h0008, 64'hF, 64'h0000_0000_0000_0000}
    };

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr2(input logic ae, input logic [15:0] aa, input logic [63:0] ad,
                       input logic be, input logic [15:0] ba, input logic [63:0] bd);
        @(negedge clk);
        wa_en = ae; wa_addr = aa; wa_data = ad;
        wb_en = be; wb_addr = ba; wb_data = bd;
        @(negedge clk);
        wa_en = 1'b0; wb_en = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [63:0] d);
        wr2(1'b1, a, d, 1'b0, 16'h0, 64'h0);
    endtask

    task automatic rd(input logic [15:0] a, output logic [63:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        check("R1 pad_oe in reset", 64'(pad_oe), 64'h0);
        rst_n = 1'b1;
        check("R1 pad_out after reset", 64'(pad_out), 64'h0);
        rd(16'h0008, d); check("R1 latch after reset", d, 64'h0);
        rd(16'h0428, d); check("R1 cfg pin5 after reset", d, 64'h0);

        for (int i = 0; i < 8; i++) begin
            wr2(VECS[i].a_en, VECS[i].a_addr, VECS[i].a_data,
                VECS[i].b_en, VECS[i].b_addr, VECS[i].b_data);
            rd(16'h0008, d);
            check($sformatf("R2/R3/R4 vector %0d", i), d, VECS[i].exp);
        end

        // R6
        rd(16'h0090, d); check("R6 capability", d, 64'h0000_0000_0000_3040);

        // R5
        pad_in = 64'hDEAD_BEEF_0123_4567;
        rd(16'h0000, d); check("R5 raw input", d, 64'hDEAD_BEEF_0123_4567);

        // R7: field masking and address of pin 4 and last pin
        wr(16'h0420, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(16'h0420, d); check("R7 cfg pin4 fields", d, 64'h0000_0000_03FF_1FFF);
        wr(16'h05F8, 64'h0000_1234_5678_9ABC);
        rd(16'h05F8, d); check("R7 cfg pin63 fields", d, 64'h0000_0000_0278_1ABC);

        // R8: push-pull on pin 3
        wr(16'h0418, 64'h1);
        wr(16'h0008, 64'h8);
        check("R8 pushpull oe", 64'(pad_oe[3]), 64'h1);
        check("R8 pushpull out", 64'(pad_out[3]), 64'h1);
        wr(16'h0418, 64'h3);
        check("R8 inverted out", 64'(pad_out[3]), 64'h0);
        check("R8 inverted oe", 64'(pad_oe[3]), 64'h1);
        wr(16'h0418, 64'h0);
        check("R8 disabled oe", 64'(pad_oe[3]), 64'h0);

        // R9: open-drain on pin 3
        wr(16'h0418, 64'h1001);
        check("R9 od high released oe", 64'(pad_oe[3]), 64'h0);
        check("R9 od out low", 64'(pad_out[3]), 64'h0);
        wr(16'h0010, 64'h8);
        check("R9 od low driven oe", 64'(pad_oe[3]), 64'h1);
        check("R9 od low out", 64'(pad_out[3]), 64'h0);
        wr(16'h0418, 64'h1003);
        check("R9 od inverted released", 64'(pad_oe[3]), 64'h0);

        // R10: pin 7 handed to another function
        wr(16'h0438, 64'h0005_0001);
        @(negedge clk);
        alt_oe[7] = 1'b1; alt_out[7] = 1'b1;
        #1;
        check("R10 alt oe", 64'(pad_oe[7]), 64'h1);
        check("R10 alt out", 64'(pad_out[7]), 64'h1);
        wr(16'h0008, 64'h80);
        rd(16'h0008, d); check("R10 latch unchanged", d, 64'h0);
        check("R10 pad still alt", 64'(pad_out[7]), 64'h1);
        alt_out[7] = 1'b0;
        #1;
        check("R10 alt out low", 64'(pad_out[7]), 64'h0);

        // R11
        wr2(1'b1, 16'h0448, 64'h1, 1'b1, 16'h0448, 64'h3);
        rd(16'h0448, d); check("R11 lane B kept", d, 64'h3);

        // R12
        rd(16'h0018, d); check("R12 gap read", d, 64'h0);
        rd(16'h0098, d); check("R12 gap after cap", d, 64'h0);
        rd(16'h0404, d); check("R12 unaligned read", d, 64'h0);
        rd(16'h0600, d); check("R12 past last pin", d, 64'h0);
        wr(16'h0018, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(16'h0404, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(16'h0600, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(16'h000C, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(16'h0008, d); check("R12 latch untouched", d, 64'h0);
        rd(16'h0400, d); check("R12 cfg pin0 untouched", d, 64'h0);
        check("R12 pin0 undriven", 64'(pad_oe[0]), 64'h0);

        // R13: read and write on the same edge
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 16'h0008;
        wa_en = 1'b1; wa_addr = 16'h0008; wa_data = 64'h5;
        @(negedge clk);
        rd_en = 1'b0; wa_en = 1'b0;
        check("R13 old value returned", rd_data, 64'h0);
        rd(16'h0008, d); check("R13 new value later", d, 64'h5);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule